// File: doc/BRIEF.md
# Inclusive Two-Level Cache Controller

This block controls a two-level cache hierarchy that keeps inclusion. The inner level is 2-way set associative with 4 sets. The outer level is direct mapped with 16 lines. A line is one data word at both levels, so an address is a line address. The CPU side has a level request with an address, a write flag and write data. The block answers with a one-cycle ready pulse. The pulse carries the read data and two flags, one for each level, that show whether the first lookup of the request hit there.

Both levels are write-back. A store that hits writes only the inner copy and marks it dirty. When the outer level has to replace a line, any inner copy of that line is invalidated first. If that inner copy is dirty, its data is merged into the outer victim, and the merged line then goes to memory. A miss in the outer tags goes to memory at once, without probing the inner level. The outer line is allocated before the inner one, and this holds for write misses too, which fetch the line before writing it. Only one request is in flight at a time. Every memory transfer holds its request until the ready handshake completes.

Top module: `cache2_top`

## Requirements
- R1: After reset both levels are empty. `cpuReady` and `memReq` are low, and the first access to any address misses both levels.
- R2: A read returns the most recent value written to that address by the CPU, or the memory value if the address was never written.
- R3: The inner set is `addr[1:0]`. A new line goes into an invalid way if there is one, and otherwise into the least recently used way of the set (one bit per set, updated on every hit and every fill). `innerHit` reports whether the first lookup hit the inner level.
- R4: The outer line is `addr[3:0]`, and a line is cached there only under its full address. `outerHit` reports whether the first lookup hit the outer level.
- R5: Inclusion. An inner hit is always reported together with an outer hit. A line replaced in the outer level is invalidated in the inner level, so its next access misses both levels.
- R6: Store hits cause no memory traffic. Data reaches memory only when a dirty outer line is replaced, and it is written with the newest CPU value of that address.
- R7: A dirty inner copy that is back-invalidated is written to memory as part of the outer victim write-back, even when the outer copy itself was clean.
- R8: An outer miss, whether read or write, performs exactly one memory read at the request address. Any hit performs none.
- R9: A write-back always comes before the fetch of the same request. `memReq`, `memWe` and `memAddr` stay stable until `memReady` is seen.
- R10: `cpuReady` is a single-cycle pulse. There is no memory request in the cycle it is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cpuReq | input | 1 | CPU request, held until `cpuReady` |
| cpuWe | input | 1 | 1 = store, 0 = load |
| cpuAddr | input | AW | Line (word) address |
| cpuWdata | input | DW | Store data |
| cpuReady | output | 1 | One-cycle completion pulse |
| cpuRdata | output | DW | Load data, valid with `cpuReady` |
| innerHit | output | 1 | First lookup hit the inner level, valid with `cpuReady` |
| outerHit | output | 1 | First lookup hit the outer level, valid with `cpuReady` |
| memReq | output | 1 | Memory transfer request |
| memWe | output | 1 | 1 = write-back, 0 = fetch |
| memAddr | output | AW | Memory line address |
| memWdata | output | DW | Write-back data |
| memRdata | input | DW | Fetch data, taken when `memReady` is high |
| memReady | input | 1 | Memory completes the transfer at this edge |

## Verification
A corrupted tag, valid or LRU bit shows up at the ports in the ready pulse of the next request that maps to the damaged set or line: the reported hit flags no longer match those of a reference model that follows the same policy. A lost dirty bit or a missed merge stays hidden until the outer line is replaced. At that point the write-back is missing, goes to the wrong address, or carries stale data. The next read of that address after it leaves the hierarchy then returns the wrong value. Running long random streams over a small address range forces frequent replacements, which keeps that delay short.

// File: rtl/cache2_pkg.sv
package cache2_pkg;

  typedef struct packed {
    logic latch;
    logic record;
    logic access;
    logic fill;
    logic backInval;
    logic install;
  } ctrlStrobeT;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOKUP,
    ST_WBACK,
    ST_FETCH,
    ST_RESP
  } ctrlStateT;

endpackage

// File: rtl/cache2_datapath.sv
module cache2_datapath import cache2_pkg::*; #(
  parameter int AW     = 8,
  parameter int DW     = 32,
  parameter int ISETS  = 4,
  parameter int OLINES = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  ctrlStrobeT    strb,
  input  logic [AW-1:0] reqAddrIn,
  input  logic          reqWeIn,
  input  logic [DW-1:0] reqDataIn,
  input  logic [DW-1:0] memRdata,
  output logic          innerHitNow,
  output logic          outerHitNow,
  output logic          victimValid,
  output logic          victimDirty,
  output logic [AW-1:0] victimAddr,
  output logic [AW-1:0] reqAddr,
  output logic [DW-1:0] victimData,
  output logic [DW-1:0] rdata,
  output logic          innerHitRec,
  output logic          outerHitRec
);
  localparam int ISW = $clog2(ISETS);
  localparam int OSW = $clog2(OLINES);

  logic          rWe;
  logic [DW-1:0] rData;

  // inner level: two ways per set
  logic [1:0]    iVal   [ISETS];
  logic [1:0]    iDirty [ISETS];
  logic [AW-1:0] iTag   [ISETS][2];
  logic [DW-1:0] iData  [ISETS][2];
  logic [ISETS-1:0] lru;              // way to replace next

  // outer level: direct mapped, full line address kept as tag
  logic [OLINES-1:0] oVal;
  logic [OLINES-1:0] oDirty;
  logic [AW-1:0]     oTag  [OLINES];
  logic [DW-1:0]     oData [OLINES];

  logic [ISW-1:0] setIdx;
  logic [OSW-1:0] lineIdx;
  logic [1:0]     hitW, vMatch;
  logic           hitWay, fillWay, evDirty, vInnerDirty;
  logic [OSW-1:0] fillOi;
  logic [DW-1:0]  vInnerData;

  assign setIdx  = reqAddr[ISW-1:0];
  assign lineIdx = reqAddr[OSW-1:0];

  always_comb begin
    for (int w = 0; w < 2; w++) begin
      hitW[w]   = iVal[setIdx][w] && (iTag[setIdx][w] == reqAddr);
      vMatch[w] = iVal[setIdx][w] && (iTag[setIdx][w] == oTag[lineIdx]);
    end
    innerHitNow = |hitW;
    hitWay      = hitW[1];
    outerHitNow = oVal[lineIdx] && (oTag[lineIdx] == reqAddr);
    victimValid = oVal[lineIdx];
    victimAddr  = oTag[lineIdx];
    victimData  = oData[lineIdx];
    vInnerDirty = |(vMatch & iDirty[setIdx]);
    victimDirty = oDirty[lineIdx] | vInnerDirty;
    vInnerData  = vMatch[1] ? iData[setIdx][1] : iData[setIdx][0];
    if (!iVal[setIdx][0])      fillWay = 1'b0;
    else if (!iVal[setIdx][1]) fillWay = 1'b1;
    else                       fillWay = lru[setIdx];
    evDirty = iVal[setIdx][fillWay] & iDirty[setIdx][fillWay];
    fillOi  = iTag[setIdx][fillWay][OSW-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < ISETS; i++) begin
        iVal[i]   <= 2'b00;
        iDirty[i] <= 2'b00;
      end
      lru         <= '0;
      oVal        <= '0;
      oDirty      <= '0;
      reqAddr     <= '0;
      rWe         <= 1'b0;
      rData       <= '0;
      rdata       <= '0;
      innerHitRec <= 1'b0;
      outerHitRec <= 1'b0;
    end else begin
      if (strb.latch) begin
        reqAddr <= reqAddrIn;
        rWe     <= reqWeIn;
        rData   <= reqDataIn;
      end
      if (strb.record) begin
        innerHitRec <= innerHitNow;
        outerHitRec <= outerHitNow;
      end
      if (strb.access) begin
        lru[setIdx] <= ~hitWay;
        if (rWe) begin
          iData[setIdx][hitWay]  <= rData;
          iDirty[setIdx][hitWay] <= 1'b1;
        end else begin
          rdata <= iData[setIdx][hitWay];
        end
      end
      if (strb.fill) begin
        if (evDirty) begin            // inner victim merges into its outer line
          oData[fillOi]  <= iData[setIdx][fillWay];
          oDirty[fillOi] <= 1'b1;
        end
        iVal[setIdx][fillWay]   <= 1'b1;
        iDirty[setIdx][fillWay] <= rWe;
        iTag[setIdx][fillWay]   <= reqAddr;
        iData[setIdx][fillWay]  <= rWe ? rData : oData[lineIdx];
        rdata                   <= oData[lineIdx];
        lru[setIdx]             <= ~fillWay;
      end
      if (strb.backInval) begin
        for (int w = 0; w < 2; w++) begin
          if (vMatch[w]) begin
            iVal[setIdx][w]   <= 1'b0;
            iDirty[setIdx][w] <= 1'b0;
          end
        end
        if (vInnerDirty) oData[lineIdx] <= vInnerData;
        oVal[lineIdx]   <= 1'b0;
        oDirty[lineIdx] <= 1'b0;
      end
      if (strb.install) begin
        oVal[lineIdx]   <= 1'b1;
        oDirty[lineIdx] <= 1'b0;
        oTag[lineIdx]   <= reqAddr;
        oData[lineIdx]  <= memRdata;
      end
    end
  end

endmodule

// File: rtl/cache2_control.sv
module cache2_control import cache2_pkg::*; (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cpuReq,
  input  logic       innerHitNow,
  input  logic       outerHitNow,
  input  logic       victimValid,
  input  logic       victimDirty,
  input  logic       memReady,
  output ctrlStrobeT strb,
  output logic       cpuReady,
  output logic       memReq,
  output logic       memWe
);
  ctrlStateT state, nextState;
  logic      firstLook;

  always_comb begin
    strb      = '0;
    nextState = state;
    cpuReady  = (state == ST_RESP);
    memReq    = (state == ST_WBACK) || (state == ST_FETCH);
    memWe     = (state == ST_WBACK);
    case (state)
      ST_IDLE: if (cpuReq) begin
        strb.latch = 1'b1;
        nextState  = ST_LOOKUP;
      end
      ST_LOOKUP: begin
        strb.record = firstLook;
        if (innerHitNow) begin
          strb.access = 1'b1;
          nextState   = ST_RESP;
        end else if (outerHitNow) begin
          strb.fill = 1'b1;
          nextState = ST_RESP;
        end else begin
          strb.backInval = victimValid;
          nextState = (victimValid && victimDirty) ? ST_WBACK : ST_FETCH;
        end
      end
      ST_WBACK: if (memReady) nextState = ST_FETCH;
      ST_FETCH: if (memReady) begin
        strb.install = 1'b1;
        nextState    = ST_LOOKUP;
      end
      ST_RESP: nextState = ST_IDLE;
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      firstLook <= 1'b0;
    end else begin
      state <= nextState;
      if (strb.latch)             firstLook <= 1'b1;
      else if (state == ST_LOOKUP) firstLook <= 1'b0;
    end
  end

endmodule

// File: rtl/cache2_top.sv
module cache2_top import cache2_pkg::*; #(
  parameter int AW     = 8,
  parameter int DW     = 32,
  parameter int ISETS  = 4,
  parameter int OLINES = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          cpuReq,
  input  logic          cpuWe,
  input  logic [AW-1:0] cpuAddr,
  input  logic [DW-1:0] cpuWdata,
  output logic          cpuReady,
  output logic [DW-1:0] cpuRdata,
  output logic          innerHit,
  output logic          outerHit,
  output logic          memReq,
  output logic          memWe,
  output logic [AW-1:0] memAddr,
  output logic [DW-1:0] memWdata,
  input  logic [DW-1:0] memRdata,
  input  logic          memReady
);
  ctrlStrobeT    strb;
  logic          innerHitNow, outerHitNow, victimValid, victimDirty;
  logic [AW-1:0] victimAddr, reqAddr;

  cache2_datapath #(.AW(AW), .DW(DW), .ISETS(ISETS), .OLINES(OLINES)) uDp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .reqAddrIn(cpuAddr), .reqWeIn(cpuWe), .reqDataIn(cpuWdata),
    .memRdata(memRdata),
    .innerHitNow(innerHitNow), .outerHitNow(outerHitNow),
    .victimValid(victimValid), .victimDirty(victimDirty),
    .victimAddr(victimAddr), .reqAddr(reqAddr), .victimData(memWdata),
    .rdata(cpuRdata), .innerHitRec(innerHit), .outerHitRec(outerHit)
  );

  cache2_control uCtl (
    .clk(clk), .rstN(rstN), .cpuReq(cpuReq),
    .innerHitNow(innerHitNow), .outerHitNow(outerHitNow),
    .victimValid(victimValid), .victimDirty(victimDirty),
    .memReady(memReady), .strb(strb),
    .cpuReady(cpuReady), .memReq(memReq), .memWe(memWe)
  );

  assign memAddr = memWe ? victimAddr : reqAddr;

endmodule

// File: rtl/cache2_checker.sv
module cache2_checker import cache2_pkg::*; #(
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rstN,
  input logic          cpuReady,
  input logic          innerHit,
  input logic          outerHit,
  input logic          memReq,
  input logic          memWe,
  input logic          memReady,
  input logic [AW-1:0] memAddr,
  input ctrlStrobeT    strb,
  input logic          dpOuterHit
);

  p_req_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memReady |=> memReq && $stable(memWe) && $stable(memAddr));

  p_wb_then_fetch_r9: assert property (@(posedge clk) disable iff (!rstN)
    memReq && memWe && memReady |=> memReq && !memWe);

  p_inclusion_r5: assert property (@(posedge clk) disable iff (!rstN)
    cpuReady && innerHit |-> outerHit);

  p_fill_from_outer_r5: assert property (@(posedge clk) disable iff (!rstN)
    strb.fill |-> dpOuterHit);

  p_evict_on_miss_r8: assert property (@(posedge clk) disable iff (!rstN)
    strb.backInval |-> !dpOuterHit);

  p_ready_pulse_r10: assert property (@(posedge clk) disable iff (!rstN)
    cpuReady |=> !cpuReady);

  p_quiet_resp_r10: assert property (@(posedge clk) disable iff (!rstN)
    cpuReady |-> !memReq);

endmodule

bind cache2_top cache2_checker #(.AW(AW)) uChk (
  .clk(clk), .rstN(rstN), .cpuReady(cpuReady),
  .innerHit(innerHit), .outerHit(outerHit),
  .memReq(memReq), .memWe(memWe), .memReady(memReady),
  .memAddr(memAddr), .strb(strb), .dpOuterHit(outerHitNow)
);

// File: tb/cache2_top_test.sv
`timescale 1ns/1ps
module cache2_top_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cpuReq = 1'b0, cpuWe = 1'b0;
  logic [7:0]  cpuAddr = '0;
  logic [31:0] cpuWdata = '0;
  logic        cpuReady, innerHit, outerHit, memReq, memWe;
  logic [31:0] cpuRdata, memWdata;
  logic [7:0]  memAddr;
  logic [31:0] memRdata = '0;
  logic        memReady = 1'b0;

  always #2.5 clk = ~clk;

  cache2_top uut (
    .clk(clk), .rstN(rstN), .cpuReq(cpuReq), .cpuWe(cpuWe),
    .cpuAddr(cpuAddr), .cpuWdata(cpuWdata), .cpuReady(cpuReady),
    .cpuRdata(cpuRdata), .innerHit(innerHit), .outerHit(outerHit),
    .memReq(memReq), .memWe(memWe), .memAddr(memAddr),
    .memWdata(memWdata), .memRdata(memRdata), .memReady(memReady)
  );

  int checks = 0, fails = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // memory and newest CPU view
  logic [31:0] memArr [256];
  logic [31:0] shadow [256];

  // reference policy model
  bit         mIVal [4][2];
  bit         mIDirty [4][2];
  logic [7:0] mITag [4][2];
  bit         mLru [4];
  bit         mOVal [16];
  bit         mODirty [16];
  logic [7:0] mOTag [16];

  function automatic void model(input logic [7:0] a, input logic we,
      output logic eI, output logic eO, output logic eWb,
      output logic [7:0] eWbA, output logic eFetch);
    int s = int'(a[1:0]);
    int o = int'(a[3:0]);
    int hw = 0;
    int v;
    bit vd;
    eI = 0; eWb = 0; eWbA = '0; eFetch = 0;
    for (int w = 0; w < 2; w++)
      if (mIVal[s][w] && mITag[s][w] == a) begin eI = 1; hw = w; end
    eO = mOVal[o] && (mOTag[o] == a);
    if (eI) begin
      if (we) mIDirty[s][hw] = 1;
      mLru[s] = (hw == 0);
      return;
    end
    if (!eO) begin
      eFetch = 1;
      if (mOVal[o]) begin
        vd = mODirty[o];
        for (int w = 0; w < 2; w++)
          if (mIVal[s][w] && mITag[s][w] == mOTag[o]) begin
            vd = vd | mIDirty[s][w];
            mIVal[s][w] = 0;
            mIDirty[s][w] = 0;
          end
        eWb = vd;
        eWbA = mOTag[o];
      end
      mOVal[o] = 1; mOTag[o] = a; mODirty[o] = 0;
    end
    if (!mIVal[s][0])      v = 0;
    else if (!mIVal[s][1]) v = 1;
    else                   v = mLru[s] ? 1 : 0;
    if (mIVal[s][v] && mIDirty[s][v]) mODirty[int'(mITag[s][v][3:0])] = 1;
    mIVal[s][v] = 1; mITag[s][v] = a; mIDirty[s][v] = we;
    mLru[s] = (v == 0);
  endfunction

  // memory responder
  int         lat = 0;
  int         wrCnt = 0, rdCnt = 0;
  logic [7:0] wrAddr = '0, rdAddr = '0;
  bit         orderBad = 0;

  initial forever begin
    @(negedge clk);
    if (memReady) begin
      memReady = 1'b0;
      lat = int'($urandom % 3);
    end else if (memReq && rstN) begin
      if (lat == 0) begin
        memReady = 1'b1;
        if (memWe) begin
          wrCnt++; wrAddr = memAddr;
          if (rdCnt != 0) orderBad = 1;
          check(memWdata == shadow[memAddr], "R6", "write-back data",
                memWdata, shadow[memAddr]);
          memArr[memAddr] = memWdata;
        end else begin
          rdCnt++; rdAddr = memAddr;
          memRdata = memArr[memAddr];
        end
      end else lat--;
    end
  end

  logic lastI, lastO;

  task automatic access(input logic [7:0] a, input logic we, input logic [31:0] d);
    logic eI, eO, eWb, eFetch;
    logic [7:0] eWbA;
    model(a, we, eI, eO, eWb, eWbA, eFetch);
    wrCnt = 0; rdCnt = 0; orderBad = 0;
    @(negedge clk);
    cpuReq = 1'b1; cpuWe = we; cpuAddr = a; cpuWdata = d;
    do @(negedge clk); while (!cpuReady);
    cpuReq = 1'b0;
    lastI = innerHit; lastO = outerHit;
    check(innerHit == eI, "R3", "inner hit flag", 32'(innerHit), 32'(eI));
    check(outerHit == eO, "R4", "outer hit flag", 32'(outerHit), 32'(eO));
    check(rdCnt == int'(eFetch), "R8", "fetch count", 32'(rdCnt), 32'(eFetch));
    if (eFetch) check(rdAddr == a, "R8", "fetch address", 32'(rdAddr), 32'(a));
    check(wrCnt == int'(eWb), "R6", "write-back count", 32'(wrCnt), 32'(eWb));
    if (eWb) check(wrAddr == eWbA, "R7", "write-back address", 32'(wrAddr), 32'(eWbA));
    check(!orderBad, "R9", "write-back after fetch", 32'(orderBad), 32'd0);
    if (!we) check(cpuRdata == shadow[a], "R2", "read data", cpuRdata, shadow[a]);
    else shadow[a] = d;
    @(negedge clk);
    check(!cpuReady, "R10", "ready pulse width", 32'(cpuReady), 32'd0);
  endtask

  initial begin
    #(150000 * 5);
    fails++; checks++;
    $display("FAIL R10 watchdog expired actual=0 expected=1");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int seedDummy;
    seedDummy = int'($urandom(32'h5eed));
    for (int i = 0; i < 256; i++) begin
      memArr[i] = 32'hA500_0000 | 32'(i);
      shadow[i] = memArr[i];
    end
    for (int s = 0; s < 4; s++) begin
      mLru[s] = 0;
      for (int w = 0; w < 2; w++) begin mIVal[s][w] = 0; mIDirty[s][w] = 0; mITag[s][w] = '0; end
    end
    for (int o = 0; o < 16; o++) begin mOVal[o] = 0; mODirty[o] = 0; mOTag[o] = '0; end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(!cpuReady, "R1", "ready after reset", 32'(cpuReady), 32'd0);
    check(!memReq, "R1", "memReq after reset", 32'(memReq), 32'd0);

    // R1: first access misses both levels
    access(8'h05, 1'b1, 32'h1111_0005);
    check(!lastI && !lastO, "R1", "first access hit flags", {30'd0, lastI, lastO}, 32'd0);
    access(8'h05, 1'b0, 0);                // inner hit, no traffic (R6)
    access(8'h05, 1'b1, 32'h2222_0005);    // store hit stays write-back
    // R5/R7: outer conflict on line 5 back-invalidates dirty inner copy
    access(8'h15, 1'b0, 0);
    access(8'h05, 1'b0, 0);
    check(!lastI && !lastO, "R5", "victim gone from both levels", {30'd0, lastI, lastO}, 32'd0);
    // R3: LRU in set 0
    access(8'h00, 1'b0, 0);
    access(8'h04, 1'b1, 32'h3333_0004);
    access(8'h00, 1'b0, 0);
    access(8'h08, 1'b0, 0);                // replaces 0x04, dirty merges to outer
    access(8'h04, 1'b0, 0);
    check(!lastI && lastO, "R3", "LRU victim still in outer", {30'd0, lastI, lastO}, 32'd1);
    access(8'h14, 1'b0, 0);                // outer eviction of dirty 0x04 (R7)

    for (int n = 0; n < 2500; n++) begin
      logic [7:0] a;
      a = ($urandom % 2 == 0) ? 8'($urandom % 32) : 8'($urandom);
      access(a, 1'($urandom % 2), $urandom);
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule